// File: doc/BRIEF.md
# Divisor Scalar Multiplication Sequencer

This block drives scalar multiplication of a divisor on the Jacobian of a genus-2 curve over a prime field. The running result is held as four field coefficients: u(x) is taken as monic of degree 2 with coefficients u1, u0, and v(x) is of degree 1 with coefficients v1, v0. Only this general divisor form is handled. The scalar sits in a shift register. The arithmetic of the group operations happens in an external engine. For each scalar bit the sequencer asks that engine for a doubling and then always for an addition with the base divisor, so the command stream is the same whatever the bit values are.

The base divisor is not kept inside the block. It is read from `base_div` throughout the run and must be held stable while `busy` is high. The field modulus and the curve coefficients are inputs. They are captured when a run starts and passed to the engine unchanged. Commands leave on a valid/ready channel: `cmd_valid` stays high, with opcode and operands frozen, until the engine raises `cmd_ready`; this is back-pressure from the engine. Only one command is outstanding at a time. The engine answers with a one-cycle `rsp_valid` strobe. The sequencer can always accept that strobe while it waits, so the response channel has no ready signal. Divisors are packed as {u1, u0, v1, v0}, u1 in the top FW bits.

Top module: `dvs_scalar_seq`

## Requirements
- R1: After reset `busy`, `done` and `cmd_valid` are 0 and `res_div` is all zeros.
- R2: For a scalar k with its leading one at bit position L, the accumulator starts at the base divisor B. The bits below L are then taken from the most significant downwards, and each one updates the accumulator to 2·acc, plus B when the bit is 1. At `done`, `res_div` holds that value.
- R3: Each scalar bit below the leading one produces exactly one doubling command (`cmd_op`=0, operand `cmd_acc`) followed by exactly one addition command (`cmd_op`=1, operands `cmd_acc` and `cmd_base` = `base_div`). A run therefore issues 2·L commands, alternating and starting with a doubling.
- R4: The addition result is written back only for a 1 bit. For a 0 bit the sum is discarded and the doubled value is kept, in the same number of cycles.
- R5: For a fixed engine timing, the number of cycles from start to `done` depends only on L and not on the values of the lower bits.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op`, `cmd_acc` and `cmd_base` stay unchanged in the next cycle. No new command is issued until the response to the previous one has arrived.
- R7: `busy` rises in the cycle after `start` is accepted and stays high up to and including the single-cycle `done` pulse. After `done`, `res_div` holds its value until the next start.
- R8: k=1 completes with `res_div` equal to `base_div`, and k=0 completes with `res_div` all zeros. Neither issues any command.
- R9: `start` is ignored while `busy` is high, and the run in progress finishes with its own scalar.
- R10: `eng_mod` and `eng_coef` take the values of `fld_mod` and `crv_coef` on the cycle `start` is accepted. They do not change while `busy` is high, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| scalar_k | input | KW | Scalar multiplier, sampled on start |
| fld_mod | input | FW | Field modulus |
| crv_coef | input | 4*FW | Curve coefficients |
| base_div | input | 4*FW | Base divisor {u1,u0,v1,v0}, held during the run |
| cmd_valid | output | 1 | Command to engine is valid |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 1 | 0 = double, 1 = add |
| cmd_acc | output | 4*FW | Accumulator operand |
| cmd_base | output | 4*FW | Base operand for additions |
| eng_mod | output | FW | Captured modulus for the engine |
| eng_coef | output | 4*FW | Captured curve coefficients for the engine |
| rsp_valid | input | 1 | One-cycle strobe: engine result valid |
| rsp_div | input | 4*FW | Engine result divisor |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| res_div | output | 4*FW | Accumulator / final result |

## Verification
A corrupted scan register or a wrong bit count shows up at the end of a run as a wrong `res_div` or as a command total other than 2·L, within one scalar's worth of engine round trips. A bad write-back decision changes the final multiple, and a 0 bit that takes a different path changes the start-to-done cycle count between scalars of equal length. Handshake faults show up in the very next cycle: operands move under back-pressure, or two operations of the same kind are issued back to back.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  localparam int NCOEF = 4;

  typedef enum logic {
    OP_DBL = 1'b0,
    OP_ADD = 1'b1
  } grp_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DBL_REQ,
    ST_DBL_WAIT,
    ST_ADD_REQ,
    ST_ADD_WAIT,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/dvs_scan.sv
module dvs_scan #(
  parameter int KW = 16,
  localparam int CW = $clog2(KW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [KW-1:0] k_in,
  output logic          cur_bit,
  output logic          k_zero,
  output logic          none_left,
  output logic          last_bit
);
  logic [KW-1:0] sreg;
  logic [CW-1:0] rem;
  logic [CW-1:0] lead;
  logic [CW-1:0] sh;

  // leading-one position of the incoming scalar
  always_comb begin
    lead = '0;
    for (int i = 0; i < KW; i++) begin
      if (k_in[i]) lead = CW'(i);
    end
    sh = CW'(KW) - lead;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '0;
      rem    <= '0;
      k_zero <= 1'b0;
    end else if (load) begin
      sreg   <= k_in << sh;
      rem    <= lead;
      k_zero <= (k_in == '0);
    end else if (shift && rem != '0) begin
      sreg <= sreg << 1;
      rem  <= rem - 1'b1;
    end
  end

  assign cur_bit   = sreg[KW-1];
  assign none_left = (rem == '0);
  assign last_bit  = (rem == CW'(1));

  // R3: each consumed bit lowers the remaining count by one
  a_r3_rem_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load && rem != '0) |=> (rem == $past(rem) - 1'b1));
endmodule

// File: rtl/dvs_acc.sv
module dvs_acc #(
  parameter int FW = 16,
  localparam int DW = dvs_pkg::NCOEF * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_base,
  input  logic          wr_rsp,
  input  logic          clr,
  input  logic [DW-1:0] base_in,
  input  logic [DW-1:0] rsp_in,
  output logic [DW-1:0] acc
);
  for (genvar c = 0; c < dvs_pkg::NCOEF; c++) begin : g_coef
    logic [FW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) r <= '0;
      else if (ld_base)  r <= base_in[c*FW +: FW];
      else if (wr_rsp)   r <= rsp_in[c*FW +: FW];
    end
    assign acc[c*FW +: FW] = r;
  end
endmodule

// File: rtl/dvs_ctrl.sv
module dvs_ctrl
  import dvs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    k_zero,
  input  logic    none_left,
  input  logic    last_bit,
  input  logic    cur_bit,
  input  logic    cmd_ready,
  input  logic    rsp_valid,
  output logic    scan_load,
  output logic    scan_shift,
  output logic    acc_ld,
  output logic    acc_wr,
  output logic    acc_clr,
  output logic    prm_ld,
  output logic    cmd_valid,
  output grp_op_e cmd_op,
  output logic    busy,
  output logic    done
);
  seq_state_e st, st_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx      = st;
    scan_load  = 1'b0;
    scan_shift = 1'b0;
    acc_ld     = 1'b0;
    acc_wr     = 1'b0;
    acc_clr    = 1'b0;
    prm_ld     = 1'b0;
    cmd_valid  = 1'b0;
    cmd_op     = OP_DBL;
    unique case (st)
      ST_IDLE: if (start) begin
        scan_load = 1'b1;
        acc_ld    = 1'b1;
        prm_ld    = 1'b1;
        st_nx     = ST_PREP;
      end
      ST_PREP: begin
        if (k_zero) begin
          acc_clr = 1'b1;
          st_nx   = ST_FIN;
        end else if (none_left) st_nx = ST_FIN;
        else                    st_nx = ST_DBL_REQ;
      end
      ST_DBL_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_DBL;
        if (cmd_ready) st_nx = ST_DBL_WAIT;
      end
      ST_DBL_WAIT: if (rsp_valid) begin
        acc_wr = 1'b1;
        st_nx  = ST_ADD_REQ;
      end
      ST_ADD_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_ADD;
        if (cmd_ready) st_nx = ST_ADD_WAIT;
      end
      ST_ADD_WAIT: if (rsp_valid) begin
        acc_wr     = cur_bit;  // sum kept only for a 1 bit
        scan_shift = 1'b1;
        st_nx      = last_bit ? ST_FIN : ST_DBL_REQ;
      end
      ST_FIN: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_FIN);

  // kind of the last command accepted by the engine
  grp_op_e last_fire;
  always_ff @(posedge clk) begin
    if (!rst_n) last_fire <= OP_ADD;
    else if (cmd_valid && cmd_ready) last_fire <= cmd_op;
  end

  // R3: accepted commands alternate double, add
  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> (cmd_op != last_fire));

  // R7: done is a single-cycle pulse that ends the busy period
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R6: no command while a response is outstanding
  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);
endmodule

// File: rtl/dvs_scalar_seq.sv
module dvs_scalar_seq
  import dvs_pkg::*;
#(
  parameter int KW = 16,
  parameter int FW = 16,
  localparam int DW = NCOEF * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] scalar_k,
  input  logic [FW-1:0] fld_mod,
  input  logic [DW-1:0] crv_coef,
  input  logic [DW-1:0] base_div,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_op,
  output logic [DW-1:0] cmd_acc,
  output logic [DW-1:0] cmd_base,
  output logic [FW-1:0] eng_mod,
  output logic [DW-1:0] eng_coef,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_div,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res_div
);
  logic    scan_load, scan_shift, acc_ld, acc_wr, acc_clr, prm_ld;
  logic    cur_bit, k_zero, none_left, last_bit;
  grp_op_e op_e;
  logic [DW-1:0] acc;

  dvs_scan #(.KW(KW)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (scan_load),
    .shift     (scan_shift),
    .k_in      (scalar_k),
    .cur_bit   (cur_bit),
    .k_zero    (k_zero),
    .none_left (none_left),
    .last_bit  (last_bit)
  );

  dvs_acc #(.FW(FW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_base (acc_ld),
    .wr_rsp  (acc_wr),
    .clr     (acc_clr),
    .base_in (base_div),
    .rsp_in  (rsp_div),
    .acc     (acc)
  );

  dvs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .k_zero     (k_zero),
    .none_left  (none_left),
    .last_bit   (last_bit),
    .cur_bit    (cur_bit),
    .cmd_ready  (cmd_ready),
    .rsp_valid  (rsp_valid),
    .scan_load  (scan_load),
    .scan_shift (scan_shift),
    .acc_ld     (acc_ld),
    .acc_wr     (acc_wr),
    .acc_clr    (acc_clr),
    .prm_ld     (prm_ld),
    .cmd_valid  (cmd_valid),
    .cmd_op     (op_e),
    .busy       (busy),
    .done       (done)
  );

  // field and curve parameters frozen for the whole run
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_mod  <= '0;
      eng_coef <= '0;
    end else if (prm_ld) begin
      eng_mod  <= fld_mod;
      eng_coef <= crv_coef;
    end
  end

  assign cmd_op   = op_e;
  assign cmd_acc  = acc;
  assign cmd_base = base_div;
  assign res_div  = acc;

  // R6: a stalled command keeps its contents
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_acc)));

  // R10: engine parameters do not move during a run
  a_r10_prm_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(eng_mod) && $stable(eng_coef)));

  // R7: result holds while idle
  a_r7_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && $past(!busy)) |=> $stable(res_div));
endmodule

// File: tb/dvs_scalar_seq_test.sv
module dvs_scalar_seq_test;
  localparam int KW = 16;
  localparam int FW = 16;
  localparam int DW = 4 * FW;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [KW-1:0] scalar_k = '0;
  logic [FW-1:0] fld_mod = '0;
  logic [DW-1:0] crv_coef = '0;
  logic [DW-1:0] base_div = '0;
  logic          cmd_valid, cmd_op, busy, done;
  logic          cmd_ready;
  logic [DW-1:0] cmd_acc, cmd_base, eng_coef, res_div;
  logic [FW-1:0] eng_mod;
  logic          rsp_valid;
  logic [DW-1:0] rsp_div;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvs_scalar_seq #(.KW(KW), .FW(FW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar_k(scalar_k),
    .fld_mod(fld_mod), .crv_coef(crv_coef), .base_div(base_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_acc(cmd_acc), .cmd_base(cmd_base), .eng_mod(eng_mod),
    .eng_coef(eng_coef), .rsp_valid(rsp_valid), .rsp_div(rsp_div),
    .busy(busy), .done(done), .res_div(res_div)
  );

  // ---------------- stub engine: coefficient-wise additive group ----------
  logic       stall_mode = 1'b0;
  int         lat_cfg = 2;
  logic [7:0] lfsr;
  logic       pend, last_op, held;
  int         cnt;
  logic       p_op;
  logic [DW-1:0] p_a, p_b, h_acc, h_base;
  logic       h_op;
  int         n_dbl, n_add, seq_err, base_err, hold_err;

  assign cmd_ready = stall_mode ? lfsr[0] : 1'b1;

  function automatic logic [DW-1:0] grp(input logic op, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b);
    logic [DW-1:0] r;
    for (int c = 0; c < 4; c++)
      r[c*FW +: FW] = op ? a[c*FW +: FW] + b[c*FW +: FW] : a[c*FW +: FW] << 1;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 8'hA5; pend <= 1'b0; cnt <= 0; rsp_valid <= 1'b0; rsp_div <= '0;
      last_op <= 1'b1; held <= 1'b0; p_op <= 1'b0; p_a <= '0; p_b <= '0;
      n_dbl <= 0; n_add <= 0; seq_err <= 0; base_err <= 0; hold_err <= 0;
      h_acc <= '0; h_base <= '0; h_op <= 1'b0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_valid <= 1'b0;
      if (held && !(cmd_valid && cmd_op == h_op && cmd_acc == h_acc && cmd_base == h_base))
        hold_err <= hold_err + 1;
      held <= cmd_valid && !cmd_ready;
      h_op <= cmd_op; h_acc <= cmd_acc; h_base <= cmd_base;
      if (!pend && cmd_valid && cmd_ready) begin
        pend <= 1'b1; cnt <= lat_cfg; p_op <= cmd_op; p_a <= cmd_acc; p_b <= cmd_base;
        if (cmd_op == last_op) seq_err <= seq_err + 1;
        last_op <= cmd_op;
        if (cmd_op) begin
          n_add <= n_add + 1;
          if (cmd_base != base_div) base_err <= base_err + 1;
        end else n_dbl <= n_dbl + 1;
      end else if (pend) begin
        if (cnt == 0) begin
          rsp_valid <= 1'b1; rsp_div <= grp(p_op, p_a, p_b); pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
    end
  end

  // ---------------- bookkeeping -----------------------------------------
  int total = 0, bad = 0;
  int cyc_all = 0;
  always @(posedge clk) cyc_all <= cyc_all + 1;

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mul_exp(input logic [KW-1:0] k, input logic [DW-1:0] b);
    logic [DW-1:0] r;
    for (int c = 0; c < 4; c++) r[c*FW +: FW] = FW'(32'(k) * 32'(b[c*FW +: FW]));
    return r;
  endfunction

  function automatic int lead_pos(input logic [KW-1:0] k);
    int p = 0;
    for (int i = 0; i < KW; i++) if (k[i]) p = i;
    return p;
  endfunction

  int run_cyc;
  int d0, a0;

  task automatic run(input logic [KW-1:0] k, input logic [DW-1:0] b);
    @(negedge clk);
    scalar_k = k; base_div = b; start = 1'b1;
    d0 = n_dbl; a0 = n_add;
    @(negedge clk);
    start = 1'b0;
    run_cyc = 0;
    while (!done && run_cyc < 5000) begin
      @(negedge clk);
      run_cyc++;
    end
    if (!done) chk(1'b0, "R7 run timeout", '0, 64'd1);
  endtask

  localparam logic [KW+DW-1:0] VEC [0:5] = '{
    {16'h0003, 16'h1234, 16'h0042, 16'hBEEF, 16'h0007},
    {16'h00A5, 16'h0001, 16'h0002, 16'h0003, 16'h0004},
    {16'h8000, 16'hFFFF, 16'h1357, 16'h2468, 16'h0F0F},
    {16'hFFFF, 16'h0101, 16'hABCD, 16'h0010, 16'h7777},
    {16'h5555, 16'h3C3C, 16'h0009, 16'hFFFE, 16'h4321},
    {16'h0102, 16'h1111, 16'h2222, 16'h3333, 16'h4444}
  };

  initial begin
    fork
      begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !cmd_valid && res_div == '0, "R1 reset state",
            {busy, done, cmd_valid}, '0);

        // R2/R3/R6 table walk under back-pressure and varied latency
        stall_mode = 1'b1;
        for (int i = 0; i < 6; i++) begin
          logic [KW-1:0] k;
          logic [DW-1:0] b;
          k = VEC[i][KW+DW-1 -: KW];
          b = VEC[i][DW-1:0];
          lat_cfg = i % 4;
          run(k, b);
          chk(res_div == mul_exp(k, b), "R2/R4 result multiple", res_div, mul_exp(k, b));
          chk(n_dbl - d0 == lead_pos(k) && n_add - a0 == lead_pos(k), "R3 command count",
              64'(n_dbl - d0 + n_add - a0), 64'(2 * lead_pos(k)));
        end
        chk(seq_err == 0, "R3 alternation", 64'(seq_err), 0);
        chk(base_err == 0, "R3 add base operand", 64'(base_err), 0);
        chk(hold_err == 0, "R6 hold under stall", 64'(hold_err), 0);

        // R4 zero bits keep doubled value: k=0b1000
        run(16'h0008, {16'd5, 16'd6, 16'd7, 16'd8});
        chk(res_div == {16'd40, 16'd48, 16'd56, 16'd64}, "R4 zero bits discard sum",
            res_div, {16'd40, 16'd48, 16'd56, 16'd64});

        // R5 constant time with fixed engine timing
        stall_mode = 1'b0; lat_cfg = 3;
        begin
          int c1, c2, c3;
          run(16'h8000, 64'h0001_0002_0003_0004); c1 = run_cyc;
          run(16'hFFFF, 64'h0001_0002_0003_0004); c2 = run_cyc;
          run(16'hA5A5, 64'h0001_0002_0003_0004); c3 = run_cyc;
          chk(c1 == c2 && c1 == c3, "R5 equal cycles same length", 64'(c2), 64'(c1));
          run(16'h0100, 64'h1); c1 = run_cyc;
          run(16'h01FF, 64'h1); c2 = run_cyc;
          chk(c1 == c2, "R5 equal cycles short length", 64'(c2), 64'(c1));
        end

        // R8 degenerate scalars
        run(16'h0001, 64'h1111_2222_3333_4444);
        chk(res_div == 64'h1111_2222_3333_4444 && n_dbl == d0 && n_add == a0,
            "R8 k=1 gives base", res_div, 64'h1111_2222_3333_4444);
        run(16'h0000, 64'h1111_2222_3333_4444);
        chk(res_div == '0 && n_dbl == d0 && n_add == a0, "R8 k=0 gives zeros", res_div, '0);

        // R7 busy / done / hold
        @(negedge clk);
        chk(!busy && !done && res_div == '0, "R7 idle after done holds", res_div, '0);

        // R9 and R10: start ignored and params frozen while busy
        @(negedge clk);
        scalar_k = 16'h00F3; base_div = 64'h0003_0005_0007_0009; start = 1'b1;
        fld_mod = 16'hFFF1; crv_coef = 64'hAAAA_BBBB_CCCC_DDDD;
        d0 = n_dbl; a0 = n_add;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R7 busy after start", {63'd0, busy}, 1);
        repeat (4) @(negedge clk);
        scalar_k = 16'hFFFF; start = 1'b1;
        fld_mod = 16'h0013; crv_coef = 64'h1;
        @(negedge clk);
        start = 1'b0;
        chk(eng_mod == 16'hFFF1 && eng_coef == 64'hAAAA_BBBB_CCCC_DDDD,
            "R10 params frozen", eng_coef, 64'hAAAA_BBBB_CCCC_DDDD);
        begin
          int w = 0;
          while (!done && w < 5000) begin @(negedge clk); w++; end
        end
        chk(res_div == mul_exp(16'h00F3, 64'h0003_0005_0007_0009), "R9 start ignored",
            res_div, mul_exp(16'h00F3, 64'h0003_0005_0007_0009));
        chk(eng_mod == 16'hFFF1, "R10 modulus kept", 64'(eng_mod), 64'hFFF1);
        @(negedge clk);
        chk(!busy && !done, "R7 done single pulse", {busy, done}, 0);
        // R10 next start captures new parameters
        run(16'h0002, 64'h1);
        chk(eng_mod == 16'h0013 && eng_coef == 64'h1, "R10 capture on start",
            64'(eng_mod), 64'h13);
      end
      begin : watchdog
        while (cyc_all < 150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'(cyc_all), 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule